// File: doc/BRIEF.md
# Synchronous Burst SRAM Address and Cycle Controller

This block is the clocked front end of a burst SRAM. On every rising clock edge it takes in the address, two chip enables, two address strobes of different priority, an advance input, a global write, a byte-write qualifier and per-byte enables. From these it classifies the cycle as idle (deselected), the start of a read or write burst, a burst step, a burst hold, or sleep. It then drives a simple synchronous array port: the word address, a read strobe and a byte-write mask. A 3-bit cycle code goes to the output stage.

The two low address bits come from a 2-bit burst counter. A strap input picks the order: counting up modulo 4, or XOR of the start offset with the count. After four steps the address is back at its start. A sleep input stops all accesses. Once sleep is released, a fixed number of recovery clocks must pass before a start command is accepted again.

Top module: `sram_burst_frontend`

## Requirements
- R1: While reset is asserted, cycleKind is 0 (idle), arrRead is 0, arrWrMask is all zeros and arrAddr is 0.
- R2: A cycle with adspN low, ce1N low and ce2 high starts a read burst (cycleKind 1) at addrIn. This holds whatever the write inputs are, so arrWrMask is 0 and arrRead is 1.
- R3: When ce1N is high, adspN is ignored. The cycle is then decided by adscN, or by advN if adscN is high.
- R4: A cycle with adscN low and adspN high (or ignored) loads addrIn. With ce1N low and ce2 high it starts a write burst (cycleKind 2) if the write decode selects any byte, and otherwise a read burst (cycleKind 1). With ce1N high it is idle (cycleKind 0).
- R5: A start cycle (adspN or adscN accepted) with ce2 low gives idle (cycleKind 0) and loads no address.
- R6: With orderSel low, the burst steps the two low address bits as start+1, start+2, start+3 and then start, all modulo 4. Steps are cycleKind 3 for a read and 4 for a write.
- R7: With orderSel high, the low address bits step as start XOR 1, start XOR 2, start XOR 3 and then start.
- R8: With both strobes high and advN high inside a burst, the address is held. cycleKind is 5 (read hold) or 6 (write hold), taken from the current write decode.
- R9: gwN low writes every byte. Otherwise, bwN low writes exactly the bytes whose byteEnN bit is low (bit i controls byte i). A cycle that selects no byte is a read.
- R10: With both strobes high and no burst open (after reset or an idle cycle), the cycle is idle whatever advN is.
- R11: A cycle sampled with sleepReq high gives cycleKind 7, arrRead 0 and arrWrMask 0, and closes any open burst.
- R12: The first RECOVER_CYC cycles sampled with sleepReq low after a sleep cycle are idle (cycleKind 0), even when a valid start is presented. The next valid start is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrIn | input | ADDR_W | External word address |
| ce1N | input | 1 | Primary chip enable, active low; also gates adspN |
| ce2 | input | 1 | Secondary chip enable, active high, used on start cycles only |
| adspN | input | 1 | Processor-side start strobe, active low, highest priority |
| adscN | input | 1 | Controller-side start strobe, active low |
| advN | input | 1 | Burst advance, active low; high holds the address |
| gwN | input | 1 | Global write, active low, all bytes |
| bwN | input | 1 | Byte-write qualifier, active low |
| byteEnN | input | NUM_BYTES | Per-byte write enables, active low |
| orderSel | input | 1 | Burst order strap: 0 counts up, 1 interleaves (XOR) |
| sleepReq | input | 1 | Sleep request, active high |
| arrAddr | output | ADDR_W | Array word address |
| arrRead | output | 1 | Array read strobe |
| arrWrMask | output | NUM_BYTES | Array byte-write mask, active high |
| cycleKind | output | 3 | Cycle code: 0 idle, 1 read start, 2 write start, 3 read step, 4 write step, 5 read hold, 6 write hold, 7 sleep |

## Verification
Every output is registered, including the address: the burst state registers feed it directly. So the cycle code, read strobe, write mask and address for a set of inputs are all due one clock after the edge that samples them. The driver task sets the inputs on a falling edge and queues the expected result at the same moment. The monitor pops one item per cycle a short delay after the next rising edge, so each comparison lands in the cycle the result is due. The recovery window after sleep is counted out cycle by cycle, with a start presented on every cycle, to pin down the exact first cycle that is accepted.

// File: rtl/burst_ctl_pkg.sv
package burst_ctl_pkg;

  typedef enum logic [2:0] {
    CYC_IDLE    = 3'd0,
    CYC_RD_NEW  = 3'd1,
    CYC_WR_NEW  = 3'd2,
    CYC_RD_NEXT = 3'd3,
    CYC_WR_NEXT = 3'd4,
    CYC_RD_HOLD = 3'd5,
    CYC_WR_HOLD = 3'd6,
    CYC_SLEEP   = 3'd7
  } cycKindT;

  // strobes from control to the address datapath
  typedef struct packed {
    logic load;
    logic step;
  } addrCmdT;

endpackage

// File: rtl/burst_addr_dp.sv
module burst_addr_dp
  import burst_ctl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  addrCmdT           cmd,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              orderSel,
  output logic [ADDR_W-1:0] arrAddr
);
  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] baseHi;
  logic [1:0]      startLo;
  logic [1:0]      cnt;
  logic            orderQ;
  logic [1:0]      lowBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseHi  <= '0;
      startLo <= '0;
      cnt     <= '0;
      orderQ  <= 1'b0;
    end else begin
      orderQ <= orderSel;
      if (cmd.load) begin
        baseHi  <= addrIn[ADDR_W-1:2];
        startLo <= addrIn[1:0];
        cnt     <= '0;
      end else if (cmd.step) begin
        cnt <= cnt + 2'd1;
      end
    end
  end

  always_comb begin
    if (orderQ) lowBits = startLo ^ cnt;
    else        lowBits = startLo + cnt;
  end

  assign arrAddr = {baseHi, lowBits};

  AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(cmd.load)) |-> (arrAddr == $past(addrIn))); // R4

  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(!cmd.load && !cmd.step) && $stable(orderQ)) |-> $stable(arrAddr)); // R8

endmodule

// File: rtl/burst_cycle_ctl.sv
module burst_cycle_ctl
  import burst_ctl_pkg::*;
#(
  parameter int NUM_BYTES   = 2,
  parameter int RECOVER_CYC = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ce1N,
  input  logic                 ce2,
  input  logic                 adspN,
  input  logic                 adscN,
  input  logic                 advN,
  input  logic                 gwN,
  input  logic                 bwN,
  input  logic [NUM_BYTES-1:0] byteEnN,
  input  logic                 sleepReq,
  output addrCmdT              cmd,
  output cycKindT              kindQ,
  output logic                 readQ,
  output logic [NUM_BYTES-1:0] maskQ
);
  localparam int REC_W = $clog2(RECOVER_CYC + 1);

  logic [NUM_BYTES-1:0] reqMask;
  logic                 isWr;
  logic                 active;
  logic                 nextActive;
  logic [REC_W-1:0]     recCnt;
  cycKindT              nextKind;
  logic [NUM_BYTES-1:0] nextMask;
  logic                 nextRead;

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_lane
    assign reqMask[i] = !gwN || (!bwN && !byteEnN[i]);
  end
  assign isWr = |reqMask;

  always_comb begin
    nextKind   = CYC_IDLE;
    cmd        = '0;
    nextActive = active;
    if (sleepReq) begin
      nextKind   = CYC_SLEEP;
      nextActive = 1'b0;
    end else if (recCnt != '0) begin
      nextActive = 1'b0;
    end else if (!adspN && !ce1N) begin
      nextActive = ce2;
      if (ce2) begin
        nextKind = CYC_RD_NEW;
        cmd.load = 1'b1;
      end
    end else if (!adscN) begin
      nextActive = !ce1N && ce2;
      if (!ce1N && ce2) begin
        nextKind = isWr ? CYC_WR_NEW : CYC_RD_NEW;
        cmd.load = 1'b1;
      end
    end else if (active) begin
      if (!advN) begin
        cmd.step = 1'b1;
        nextKind = isWr ? CYC_WR_NEXT : CYC_RD_NEXT;
      end else begin
        nextKind = isWr ? CYC_WR_HOLD : CYC_RD_HOLD;
      end
    end
  end

  always_comb begin
    nextRead = (nextKind == CYC_RD_NEW) || (nextKind == CYC_RD_NEXT) ||
               (nextKind == CYC_RD_HOLD);
    nextMask = ((nextKind == CYC_WR_NEW) || (nextKind == CYC_WR_NEXT) ||
                (nextKind == CYC_WR_HOLD)) ? reqMask : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kindQ  <= CYC_IDLE;
      readQ  <= 1'b0;
      maskQ  <= '0;
      active <= 1'b0;
      recCnt <= '0;
    end else begin
      kindQ  <= nextKind;
      readQ  <= nextRead;
      maskQ  <= nextMask;
      active <= nextActive;
      if (sleepReq)           recCnt <= REC_W'(RECOVER_CYC);
      else if (recCnt != '0)  recCnt <= recCnt - 1'b1;
    end
  end

  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(sleepReq)) |-> (kindQ == CYC_SLEEP && !readQ && maskQ == '0)); // R11

  AST_RECOVER_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (recCnt != '0 && !sleepReq) |=> (kindQ == CYC_IDLE)); // R12

  AST_PROC_READ: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(!sleepReq && recCnt == '0 && !adspN && !ce1N && ce2))
      |-> (readQ && maskQ == '0)); // R2

  AST_GLOBAL_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(!sleepReq && recCnt == '0 && adspN && !adscN && !ce1N && ce2 && !gwN))
      |-> (maskQ == '1)); // R9

endmodule

// File: rtl/sram_burst_frontend.sv
module sram_burst_frontend
  import burst_ctl_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int NUM_BYTES   = 2,
  parameter int RECOVER_CYC = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    addrIn,
  input  logic                 ce1N,
  input  logic                 ce2,
  input  logic                 adspN,
  input  logic                 adscN,
  input  logic                 advN,
  input  logic                 gwN,
  input  logic                 bwN,
  input  logic [NUM_BYTES-1:0] byteEnN,
  input  logic                 orderSel,
  input  logic                 sleepReq,
  output logic [ADDR_W-1:0]    arrAddr,
  output logic                 arrRead,
  output logic [NUM_BYTES-1:0] arrWrMask,
  output logic [2:0]           cycleKind
);
  addrCmdT cmd;
  cycKindT kindQ;

  burst_cycle_ctl #(
    .NUM_BYTES  (NUM_BYTES),
    .RECOVER_CYC(RECOVER_CYC)
  ) u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .ce1N    (ce1N),
    .ce2     (ce2),
    .adspN   (adspN),
    .adscN   (adscN),
    .advN    (advN),
    .gwN     (gwN),
    .bwN     (bwN),
    .byteEnN (byteEnN),
    .sleepReq(sleepReq),
    .cmd     (cmd),
    .kindQ   (kindQ),
    .readQ   (arrRead),
    .maskQ   (arrWrMask)
  );

  burst_addr_dp #(
    .ADDR_W(ADDR_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .addrIn  (addrIn),
    .orderSel(orderSel),
    .arrAddr (arrAddr)
  );

  assign cycleKind = kindQ;

endmodule

// File: tb/sram_burst_frontend_bench.sv
module sram_burst_frontend_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] addrIn = '0;
  logic       ce1N = 1'b0, ce2 = 1'b1, adspN = 1'b1, adscN = 1'b1, advN = 1'b1;
  logic       gwN = 1'b1, bwN = 1'b1, orderSel = 1'b0, sleepReq = 1'b0;
  logic [1:0] byteEnN = 2'b11;
  logic [7:0] arrAddr;
  logic       arrRead;
  logic [1:0] arrWrMask;
  logic [2:0] cycleKind;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int         kind;
    int         addr;
    logic [1:0] mask;
    string      tag;
  } expT;
  expT expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_burst_frontend u_sram_burst_frontend (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .ce1N(ce1N), .ce2(ce2),
    .adspN(adspN), .adscN(adscN), .advN(advN), .gwN(gwN), .bwN(bwN),
    .byteEnN(byteEnN), .orderSel(orderSel), .sleepReq(sleepReq),
    .arrAddr(arrAddr), .arrRead(arrRead), .arrWrMask(arrWrMask), .cycleKind(cycleKind)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // driver: set inputs for one cycle and queue the expected registered result
  task automatic drive(input logic c1, input logic c2, input logic sp, input logic sc,
                       input logic av, input logic g, input logic bw, input logic [1:0] be,
                       input logic [7:0] a, input logic ord, input logic sl,
                       input int kind, input int ea, input logic [1:0] em, input string tag);
    expT e;
    @(negedge clk);
    ce1N = c1; ce2 = c2; adspN = sp; adscN = sc; advN = av;
    gwN = g; bwN = bw; byteEnN = be; addrIn = a; orderSel = ord; sleepReq = sl;
    e.kind = kind; e.addr = ea; e.mask = em; e.tag = tag;
    expQ.push_back(e);
  endtask

  // monitor: results are due one clock after the sampling edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        expT e;
        logic expRd;
        e = expQ.pop_front();
        expRd = (e.kind == 1) || (e.kind == 3) || (e.kind == 5);
        check(cycleKind == 3'(e.kind), {e.tag, " kind"}, cycleKind, e.kind);
        check(arrRead == expRd, {e.tag, " read"}, arrRead, expRd);
        check(arrWrMask == e.mask, {e.tag, " mask"}, arrWrMask, e.mask);
        if (e.addr >= 0)
          check(arrAddr == 8'(e.addr), {e.tag, " addr"}, arrAddr, e.addr);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check(cycleKind == 3'd0, "R1 reset kind", cycleKind, 0);
    check(arrRead == 1'b0, "R1 reset read", arrRead, 0);
    check(arrWrMask == 2'b00, "R1 reset mask", arrWrMask, 0);
    check(arrAddr == 8'h00, "R1 reset addr", arrAddr, 0);
    @(negedge clk);
    rstN = 1'b1;

    drive(0,1,1,1,0,1,1,2'b11,8'h00,0,0, 0,-1,2'b00,"R10 advance with no burst");
    drive(0,1,0,1,1,0,0,2'b00,8'h5D,0,0, 1,'h5D,2'b00,"R2 proc start reads despite writes");
    drive(0,1,1,1,0,1,1,2'b11,8'h00,0,0, 3,'h5E,2'b00,"R6 linear step 1");
    drive(0,1,1,1,0,1,1,2'b11,8'h00,0,0, 3,'h5F,2'b00,"R6 linear step 2");
    drive(0,1,1,1,0,1,1,2'b11,8'h00,0,0, 3,'h5C,2'b00,"R6 linear step 3 modulo");
    drive(0,1,1,1,0,1,1,2'b11,8'h00,0,0, 3,'h5D,2'b00,"R6 linear wrap to start");
    drive(0,1,1,1,1,1,1,2'b11,8'h00,0,0, 5,'h5D,2'b00,"R8 read hold");
    drive(0,1,1,0,1,0,1,2'b11,8'h30,0,0, 2,'h30,2'b11,"R4 R9 ctrl start global write");
    drive(0,1,1,1,0,1,0,2'b10,8'h00,0,0, 4,'h31,2'b01,"R9 byte 0 write step");
    drive(0,1,1,1,1,1,0,2'b01,8'h00,0,0, 6,'h31,2'b10,"R8 write hold byte 1");
    drive(0,1,1,1,0,1,0,2'b11,8'h00,0,0, 3,'h32,2'b00,"R9 no lane selected is read");
    drive(0,1,1,0,1,1,1,2'b11,8'h44,0,0, 1,'h44,2'b00,"R4 ctrl start read");
    drive(1,1,0,1,0,1,1,2'b11,8'h99,0,0, 3,'h45,2'b00,"R3 proc strobe ignored, burst steps");
    drive(1,1,0,0,1,0,1,2'b11,8'h77,0,0, 0,-1,2'b00,"R3 R4 ctrl start with ce1 off");
    drive(0,1,1,1,0,1,1,2'b11,8'h00,0,0, 0,-1,2'b00,"R10 advance after idle");
    drive(0,0,0,1,1,1,1,2'b11,8'h11,0,0, 0,-1,2'b00,"R5 proc start ce2 low");
    drive(0,0,1,0,1,0,1,2'b11,8'h11,0,0, 0,-1,2'b00,"R5 ctrl start ce2 low");
    drive(0,1,1,1,1,1,1,2'b11,8'h00,0,0, 0,-1,2'b00,"R5 R10 hold stays idle");
    drive(0,1,0,1,1,1,1,2'b11,8'h5D,1,0, 1,'h5D,2'b00,"R7 interleaved start");
    drive(0,1,1,1,0,1,1,2'b11,8'h00,1,0, 3,'h5C,2'b00,"R7 xor 1");
    drive(0,1,1,1,0,1,1,2'b11,8'h00,1,0, 3,'h5F,2'b00,"R7 xor 2");
    drive(0,1,1,1,0,1,1,2'b11,8'h00,1,0, 3,'h5E,2'b00,"R7 xor 3");
    drive(0,1,1,1,0,1,1,2'b11,8'h00,1,0, 3,'h5D,2'b00,"R7 wrap to start");
    drive(0,1,0,1,1,1,1,2'b11,8'h12,0,1, 7,-1,2'b00,"R11 sleep blocks start");
    drive(0,1,1,0,1,0,1,2'b11,8'h12,0,1, 7,-1,2'b00,"R11 sleep blocks write");
    drive(0,1,0,1,1,1,1,2'b11,8'h12,0,0, 0,-1,2'b00,"R12 recovery 1");
    drive(0,1,0,1,1,1,1,2'b11,8'h12,0,0, 0,-1,2'b00,"R12 recovery 2");
    drive(0,1,0,1,1,1,1,2'b11,8'h12,0,0, 0,-1,2'b00,"R12 recovery 3");
    drive(0,1,0,1,1,1,1,2'b11,8'h12,0,0, 1,'h12,2'b00,"R12 start accepted after recovery");
    drive(0,1,1,1,0,1,1,2'b11,8'h00,0,0, 3,'h13,2'b00,"R6 step after recovery");
    drive(0,1,1,1,1,1,1,2'b11,8'h00,0,0, 5,'h13,2'b00,"R8 hold after recovery");

    @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule